// File: doc/BRIEF.md
# Audio Link Input Frame Receiver

This block sits on the controller side of a serial audio codec link and turns the codec's serial input stream back into parallel fields. It runs entirely on the link bit clock. It watches the frame sync that the controller itself drives, and it samples the serial data line on every falling clock edge. It counts the bits of each 256-bit frame and picks the fields it needs out of the stream as they pass.

Each frame opens with a 16-bit tag slot. It is followed by twelve 20-bit slots, each sent MSB first. The tag carries a codec-ready flag in its top bit and one valid flag for each slot. The receiver presents the latest tag and the per-slot valid flags. It also presents the register address and read-back data that the codec echoes, plus the left and right capture samples.

All outputs change together, once per completed frame, and a one-cycle done strobe marks that moment. A field whose valid flag is clear keeps its old value. If a new sync edge arrives before the frame is complete, the partial frame is dropped without a done strobe.

Top module: `aclink_rx_deframer`

## Requirements
- R1: While reset is asserted, every field output (tag, codec_rdy, slot_vld, reg_addr, reg_data, pcm_left, pcm_right) is zero and frame_done is low.
- R2: After a complete frame, tag equals the first 16 bits received, with the first bit in tag[15], and codec_rdy equals that first bit.
- R3: slot_vld[k-1] equals tag bit 15-k for slot k, 1 to 12; for example, slot_vld[0] equals tag[14] and slot_vld[11] equals tag[3].
- R4: When tag[14] is set in a complete frame, reg_addr takes bits 18:12 of slot 1 (frame bits 16 to 35, the first bit being slot bit 19).
- R5: When tag[13] is set in a complete frame, reg_data takes bits 19:4 of slot 2 (frame bits 36 to 55).
- R6: When tag[12] is set in a complete frame, pcm_left takes all 20 bits of slot 3 (frame bits 56 to 75). When tag[11] is set, pcm_right takes slot 4 (frame bits 76 to 95).
- R7: A field whose tag valid bit is clear in a complete frame keeps the value it held before that frame.
- R8: frame_done is high for exactly one bit-clock cycle, starting at the falling edge that samples bit 256 of a frame. Bit 1 is the bit sampled one falling edge after the falling edge that first sees sync high after low. No output changes at any other time.
- R9: A sync rising edge seen before 256 bits have been sampled drops the partial frame: there is no done strobe, the outputs stay unchanged, and counting restarts, so the next complete frame decodes correctly.
- R10: Without a sync rising edge, no done strobe occurs, both before the first frame and after a completed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Link bit clock; data is sampled on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | Frame sync; a low-to-high change starts a frame |
| sd_in | input | 1 | Serial data from the codec, MSB first |
| tag | output | 16 | Tag slot of the last complete frame |
| codec_rdy | output | 1 | Codec-ready flag (tag bit 15) |
| slot_vld | output | 12 | Per-slot valid flags, bit k-1 for slot k |
| reg_addr | output | 7 | Echoed register address |
| reg_data | output | 16 | Register read-back data |
| pcm_left | output | 20 | Left capture sample |
| pcm_right | output | 20 | Right capture sample |
| frame_done | output | 1 | One-cycle strobe when a frame completes |

## Verification
A bit counter that is off by even one position shifts every extracted field. The error shows on the first complete frame that carries a nonzero pattern. A wrong count also moves frame_done away from the 256th falling edge after the sync edge, so it is caught at the end of that same frame. Stale or leaked valid gating shows as a field that changes when its flag is clear, or that holds when its flag is set, and this is visible at the next done strobe. A sync edge detector that misses a restart produces a done strobe, or changed outputs, right after a truncated frame.

// File: rtl/aclink_rx_deframer.sv
`timescale 1ns/1ps
module aclink_rx_deframer #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 16
) (
  input  logic                 bit_clk,
  input  logic                 rst_n,
  input  logic                 sync,
  input  logic                 sd_in,
  output logic [TAG_W-1:0]     tag,
  output logic                 codec_rdy,
  output logic [NUM_SLOTS-1:0] slot_vld,
  output logic [ADDR_W-1:0]    reg_addr,
  output logic [DATA_W-1:0]    reg_data,
  output logic [SLOT_W-1:0]    pcm_left,
  output logic [SLOT_W-1:0]    pcm_right,
  output logic                 frame_done
);

  localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] END_TAG = CNT_W'(TAG_W - 1);
  localparam logic [CNT_W-1:0] END_S1  = CNT_W'(TAG_W + SLOT_W - 1);
  localparam logic [CNT_W-1:0] END_S2  = CNT_W'(TAG_W + 2 * SLOT_W - 1);
  localparam logic [CNT_W-1:0] END_S3  = CNT_W'(TAG_W + 3 * SLOT_W - 1);
  localparam logic [CNT_W-1:0] END_S4  = CNT_W'(TAG_W + 4 * SLOT_W - 1);
  localparam logic [CNT_W-1:0] END_FRM = CNT_W'(FRAME_BITS - 1);
  localparam int V_S1 = TAG_W - 2;
  localparam int V_S2 = TAG_W - 3;
  localparam int V_S3 = TAG_W - 4;
  localparam int V_S4 = TAG_W - 5;

  logic              sync_q;
  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] shreg;
  logic [SLOT_W-1:0] shreg_nxt;
  logic [TAG_W-1:0]  tag_stg;
  logic [ADDR_W-1:0] addr_stg;
  logic [DATA_W-1:0] data_stg;
  logic [SLOT_W-1:0] left_stg;
  logic [SLOT_W-1:0] right_stg;

  wire sync_rise = sync & ~sync_q;
  wire last_bit  = active & (cnt == END_FRM);

  assign shreg_nxt = {shreg[SLOT_W-2:0], sd_in};
  assign codec_rdy = tag[TAG_W-1];

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_vld
    assign slot_vld[k] = tag[TAG_W-2-k];
  end

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b1;
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else begin
      sync_q <= sync;
      if (active) shreg <= shreg_nxt;
      if (sync_rise) begin
        cnt    <= '0;
        active <= 1'b1;
      end else if (active) begin
        cnt <= cnt + 1'b1;
        if (last_bit) active <= 1'b0;
      end
    end
  end

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_stg   <= '0;
      addr_stg  <= '0;
      data_stg  <= '0;
      left_stg  <= '0;
      right_stg <= '0;
    end else if (active) begin
      if (cnt == END_TAG) tag_stg   <= shreg_nxt[TAG_W-1:0];
      if (cnt == END_S1)  addr_stg  <= shreg_nxt[SLOT_W-2 -: ADDR_W];
      if (cnt == END_S2)  data_stg  <= shreg_nxt[SLOT_W-1 -: DATA_W];
      if (cnt == END_S3)  left_stg  <= shreg_nxt;
      if (cnt == END_S4)  right_stg <= shreg_nxt;
    end
  end

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      tag        <= '0;
      reg_addr   <= '0;
      reg_data   <= '0;
      pcm_left   <= '0;
      pcm_right  <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= last_bit;
      if (last_bit) begin
        tag <= tag_stg;
        if (tag_stg[V_S1]) reg_addr  <= addr_stg;
        if (tag_stg[V_S2]) reg_data  <= data_stg;
        if (tag_stg[V_S3]) pcm_left  <= left_stg;
        if (tag_stg[V_S4]) pcm_right <= right_stg;
      end
    end
  end

endmodule

module aclink_rx_deframer_chk #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int ADDR_W    = 7
) (
  input logic              bit_clk,
  input logic              rst_n,
  input logic              sync,
  input logic              frame_done,
  input logic [TAG_W-1:0]  tag,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [SLOT_W-1:0] pcm_left
);
  localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int SEEN_W     = $clog2(FRAME_BITS) + 2;
  localparam logic [SEEN_W-1:0] IDLE = SEEN_W'(FRAME_BITS + 40);
  localparam logic [SEEN_W-1:0] LAST = SEEN_W'(FRAME_BITS - 1);

  logic              sync_d;
  logic [SEEN_W-1:0] seen;

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d <= 1'b1;
      seen   <= IDLE;
    end else begin
      sync_d <= sync;
      if (sync && !sync_d) seen <= '0;
      else if (seen < IDLE) seen <= seen + 1'b1;
    end
  end

  // R8
  done_pulse_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R8
  done_timing_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    frame_done |-> $past(seen) == LAST);

  // R8
  tag_hold_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !frame_done |-> $stable(tag));

  // R7
  addr_hold_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (frame_done && !tag[TAG_W-2]) |-> $stable(reg_addr));

  // R7
  left_hold_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (frame_done && !tag[TAG_W-4]) |-> $stable(pcm_left));
endmodule

bind aclink_rx_deframer aclink_rx_deframer_chk #(
  .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)
) u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync), .frame_done(frame_done),
  .tag(tag), .reg_addr(reg_addr), .pcm_left(pcm_left)
);

// File: tb/aclink_rx_deframer_bench.sv
`timescale 1ns/1ps
module aclink_rx_deframer_bench;
  logic        bit_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        sd_in = 1'b0;
  logic [15:0] tag;
  logic        codec_rdy;
  logic [11:0] slot_vld;
  logic [6:0]  reg_addr;
  logic [15:0] reg_data;
  logic [19:0] pcm_left;
  logic [19:0] pcm_right;
  logic        frame_done;

  aclink_rx_deframer u_aclink_rx_deframer (
    .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync), .sd_in(sd_in),
    .tag(tag), .codec_rdy(codec_rdy), .slot_vld(slot_vld),
    .reg_addr(reg_addr), .reg_data(reg_data),
    .pcm_left(pcm_left), .pcm_right(pcm_right), .frame_done(frame_done)
  );

  always #2.5 bit_clk = ~bit_clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [15:0] e_tag   = '0;
  logic [6:0]  e_addr  = '0;
  logic [15:0] e_data  = '0;
  logic [19:0] e_left  = '0;
  logic [19:0] e_right = '0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input logic [15:0] t, input logic [19:0] s1,
      input logic [19:0] s2, input logic [19:0] s3, input logic [19:0] s4);
    return {t, s1, s2, s3, s4, 160'b0};
  endfunction

  function automatic logic [11:0] vld_of(input logic [15:0] t);
    logic [11:0] v;
    for (int k = 1; k <= 12; k++) v[k-1] = t[15-k];
    return v;
  endfunction

  task automatic check_fields(input string rq);
    chk("R2", {rq, " tag"}, tag, e_tag);
    chk("R2", {rq, " codec_rdy"}, codec_rdy, e_tag[15]);
    chk("R3", {rq, " slot_vld"}, slot_vld, vld_of(e_tag));
    chk(e_tag[14] ? "R4" : "R7", {rq, " reg_addr"}, reg_addr, e_addr);
    chk(e_tag[13] ? "R5" : "R7", {rq, " reg_data"}, reg_data, e_data);
    chk(e_tag[12] ? "R6" : "R7", {rq, " pcm_left"}, pcm_left, e_left);
    chk(e_tag[11] ? "R6" : "R7", {rq, " pcm_right"}, pcm_right, e_right);
  endtask

  // started: sync already raised by previous call; chain: raise sync with last bit
  task automatic send(input logic [255:0] f, input int len, input bit started,
                      input bit chain, input string rq);
    if (!started) begin
      @(posedge bit_clk); #1;
      sync = 1'b1;
    end
    for (int j = 1; j <= len; j++) begin
      @(posedge bit_clk); #1;
      if (j == 2) chk("R8", {rq, " done drops"}, frame_done, 1'b0);
      sd_in = f[256-j];
      sync  = (j < 16) || (chain && j == len);
    end
    @(negedge bit_clk); #1;
    if (len == 256) begin
      e_tag = f[255:240];
      if (f[254]) e_addr  = f[238:232];
      if (f[253]) e_data  = f[219:204];
      if (f[252]) e_left  = f[199:180];
      if (f[251]) e_right = f[179:160];
      chk("R8", {rq, " done"}, frame_done, 1'b1);
    end else begin
      chk("R9", {rq, " no done on partial"}, frame_done, 1'b0);
    end
    check_fields(rq);
  endtask

  task automatic idle_check(input string what);
    int pulses = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge bit_clk); #1;
      if (frame_done) pulses++;
    end
    chk("R10", what, pulses, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge bit_clk);
    #1;
    chk("R1", "tag in reset", tag, 0);
    chk("R1", "rdy in reset", codec_rdy, 0);
    chk("R1", "vld in reset", slot_vld, 0);
    chk("R1", "addr in reset", reg_addr, 0);
    chk("R1", "data in reset", reg_data, 0);
    chk("R1", "left in reset", pcm_left, 0);
    chk("R1", "right in reset", pcm_right, 0);
    chk("R1", "done in reset", frame_done, 0);
    rst_n = 1'b1;
    idle_check("no done before first sync");

    // all slots valid, distinct patterns
    send(mk(16'hFFF8, 20'hA5F00, 20'h1234F, 20'hABCDE, 20'h13579), 256, 0, 1, "R4 full");
    // codec not ready, nothing valid: fields must hold
    send(mk(16'h0000, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF), 256, 1, 1, "R7 none");
    // only left and addr valid, back to back
    send(mk(16'hD000, 20'h5A000, 20'h77770, 20'h80001, 20'hFFFFF), 256, 1, 1, "R6 part");
    // truncated frame then a full frame
    send(mk(16'hFFF8, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF), 40, 1, 1, "R9 cut");
    send(mk(16'hB800, 20'h3F000, 20'hC0DE0, 20'h0000F, 20'h24680), 256, 1, 0, "R9 after");
    idle_check("no done after completed frame");

    begin
      bit chained = 1'b0;
      for (int i = 0; i < 40; i++) begin
        logic [255:0] f;
        int len;
        bit chain;
        f = mk(16'($urandom), 20'($urandom), 20'($urandom), 20'($urandom), 20'($urandom));
        len = ($urandom % 5 == 0) ? 17 + int'($urandom % 239) : 256;
        chain = (len != 256) || (i < 39 && $urandom % 2 == 1);
        if (i == 39 && len != 256) len = 256;
        if (i == 39) chain = 1'b0;
        send(f, len, chained, chain, len == 256 ? "R2 rand" : "R9 rand");
        chained = chain;
      end
    end
    idle_check("no done after random run");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bit_clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule